// File: doc/BRIEF.md
# Four-Channel Banked-Increment Oscillator with Two Interleaved Lanes

This block is a numerically controlled oscillator that runs four independent channels. Each channel has its own 24-bit phase accumulator. The increment it adds on each step comes from a table of eight banks, with four entries per bank (one per channel). A bank select input chooses which bank drives the channels. The four sine outputs leave on two 16-bit lanes that are time-multiplexed:

- In slot 0, lane 0 carries channel 0 and lane 1 carries channel 1.
- In slot 1, lane 0 carries channel 2 and lane 1 carries channel 3.

A one-bit slot index travels with every valid output pair. A bank-match strobe marks the samples whose bank equals a bank number fixed at build time, so downstream logic can extract the waveform of one chosen bank.

Slot sequencing is a two-state machine:
- **SLOT_EVEN** is the reset state. On the ADVANCE transition (a cycle with `in_valid` high) it moves to SLOT_ODD.
- **SLOT_ODD** returns to SLOT_EVEN on ADVANCE.
- With `in_valid` low, the HOLD transition keeps the current state.

In SLOT_EVEN the bank select is taken live and latched as the frame bank. In SLOT_ODD the latched frame bank is used, so both halves of a frame share one bank. A bank change alters the frequency at once but never clears phase, so the waveform bends at the switch point without a phase jump.

Top module: `mcnco_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four phase accumulators, returns the slot machine to SLOT_EVEN, and drives `out_valid`, `out_hit`, `out_slot`, `out_bank`, `lane0_wave` and `lane1_wave` to zero.
- R2: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. A cycle with `in_valid` low changes no accumulator and no slot.
- R3: Each accumulator is 24 bits wide and wraps modulo 2^24. On a valid cycle, the accumulator of each channel in the current slot adds its increment. The emitted sample uses the phase before that add.
- R4: The sample value is round-half-away-from-zero of 32767·sin(2π·k/1024), where k is phase bits [23:14]. It is presented as 16-bit two's complement.
- R5: In slot s, lane 0 carries channel 2·s and lane 1 carries channel 2·s+1. `out_slot` shows s (0 or 1), never the global channel number.
- R6: The slot index starts at 0 after reset and toggles on every valid input cycle, so consecutive valid outputs alternate 0,1,0,1.
- R7: When `cfg_we` is high at an edge, entry (`cfg_bank`, `cfg_chan`) of the increment table becomes `cfg_inc`. A valid sample taken on that same edge still uses the old entry, and later samples use the new one.
- R8: In slot 0 the active bank is `bank_sel`, and it is latched. In slot 1 the latched value is used and `bank_sel` is ignored. `out_bank` reports the bank used for that sample.
- R9: A bank change never alters accumulator contents. Phase continues from where it was, and only the step size changes.
- R10: `out_hit` is high exactly when `out_valid` is high and `out_bank` equals the build-time bank number `EXTRACT_BANK` (default 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Increment table write enable |
| cfg_bank | input | 3 | Bank of the table entry to write |
| cfg_chan | input | 2 | Channel of the table entry to write |
| cfg_inc | input | 24 | Increment value to write |
| bank_sel | input | 3 | Requested bank, sampled in slot 0 |
| in_valid | input | 1 | Advance strobe: one slot step per high cycle |
| out_valid | output | 1 | Output pair is valid |
| out_slot | output | 1 | Slot index of the output pair (0 or 1) |
| out_bank | output | 3 | Bank used for the output pair |
| out_hit | output | 1 | Valid sample of the extracted bank |
| lane0_wave | output | 16 | Signed sine sample for channel 0 or 2 |
| lane1_wave | output | 16 | Signed sine sample for channel 1 or 3 |

## Verification
The bench attacks the following corner cases. Each is paired with the failure it exposes.

- **Bank requests that change on odd slots.** A design that sampled the bank every cycle would split a frame across two banks and report a mismatched `out_bank` on slot 1.
- **Gapped valid patterns.** A slot machine that advanced on idle cycles would swap channels between the lanes.
- **A table write in the same cycle as a valid sample.** A write-through path would use the new increment one sample early.
- **Long runs on a bank with near-full-scale increments.** A wrong wrap or a post-add read of the accumulator would shift every sample.
- **A reset in mid-stream.** A design that kept stale phase would not restart at zero.
- **Bank switching while running.** A design that cleared phase on a bank switch would show a phase jump that the reference does not have.

// File: rtl/mcnco_pkg.sv
package mcnco_pkg;

    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;

    // Rounded full-scale sine code for table index idx of depth entries.
    function automatic int sine_code(input int idx, input int depth, input int dw);
        real ang;
        real amp;
        real x;
        ang = 2.0 * $acos(-1.0) * real'(idx) / real'(depth);
        amp = real'((1 << (dw - 1)) - 1);
        x   = amp * $sin(ang);
        if (x < 0.0)
            return $rtoi(x - 0.5);
        return $rtoi(x + 0.5);
    endfunction

endpackage

// File: rtl/mcnco_slot_fsm.sv
module mcnco_slot_fsm
    import mcnco_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BANK_W-1:0] bank_sel,
    output slot_e             slot,
    output logic [BANK_W-1:0] bank_eff
);

    slot_e             state_q;
    slot_e             state_d;
    logic [BANK_W-1:0] frame_bank_q;

    // State register and frame bank latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SLOT_EVEN;
            frame_bank_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && (state_q == SLOT_EVEN))
                frame_bank_q <= bank_sel;
        end
    end

    // Transitions: ADVANCE on in_valid, HOLD otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EVEN: if (in_valid) state_d = SLOT_ODD;
            SLOT_ODD:  if (in_valid) state_d = SLOT_EVEN;
            default:   state_d = SLOT_EVEN;
        endcase
    end

    // Outputs
    always_comb begin
        slot = state_q;
        unique case (state_q)
            SLOT_EVEN: bank_eff = bank_sel;
            SLOT_ODD:  bank_eff = frame_bank_q;
            default:   bank_eff = bank_sel;
        endcase
    end

endmodule

// File: rtl/mcnco_inc_table.sv
module mcnco_inc_table #(
    parameter int BANKS  = 8,
    parameter int CH     = 4,
    parameter int LANES  = 2,
    parameter int PW     = 24,
    parameter int SLOT_W = 1
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(BANKS)-1:0] wr_bank,
    input  logic [$clog2(CH)-1:0]    wr_chan,
    input  logic [PW-1:0]            wr_data,
    input  logic [$clog2(BANKS)-1:0] rd_bank,
    input  logic [SLOT_W-1:0]        rd_slot,
    output logic [PW-1:0]            rd_inc [LANES]
);

    localparam int CH_W = $clog2(CH);

    logic [PW-1:0] tbl_q [BANKS][CH];

    always_ff @(posedge clk) begin
        if (wr_en)
            tbl_q[wr_bank][wr_chan] <= wr_data;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        logic [CH_W-1:0] chan_idx;
        assign chan_idx  = CH_W'(int'(rd_slot) * LANES + l);
        assign rd_inc[l] = tbl_q[rd_bank][chan_idx];
    end

endmodule

// File: rtl/mcnco_phase_bank.sv
module mcnco_phase_bank #(
    parameter int CH     = 4,
    parameter int LANES  = 2,
    parameter int PW     = 24,
    parameter int AW     = 10,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PW-1:0]     inc [LANES],
    output logic [AW-1:0]     addr_q [LANES]
);

    localparam int CH_W = $clog2(CH);

    logic [PW-1:0] acc_v [CH];

    for (genvar c = 0; c < CH; c++) begin : g_acc
        localparam int LANE    = c % LANES;
        localparam int MY_SLOT = c / LANES;
        logic [PW-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (rst)
                acc_q <= '0;
            else if (step && (slot == SLOT_W'(MY_SLOT)))
                acc_q <= acc_q + inc[LANE];
        end
        assign acc_v[c] = acc_q;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_addr
        logic [CH_W-1:0] chan_idx;
        assign chan_idx = CH_W'(int'(slot) * LANES + l);
        always_ff @(posedge clk) begin
            if (rst)
                addr_q[l] <= '0;
            else if (step)
                addr_q[l] <= acc_v[chan_idx][PW-1 -: AW];
        end
    end

endmodule

// File: rtl/mcnco_sine_rom.sv
module mcnco_sine_rom #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic [AW-1:0]        addr,
    output logic signed [DW-1:0] data_q
);

    localparam int DEPTH = 1 << AW;

    logic signed [DW-1:0] rom [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            rom[i] = DW'(mcnco_pkg::sine_code(i, DEPTH, DW));
    end

    always_ff @(posedge clk) begin
        if (en)
            data_q <= rom[addr];
    end

endmodule

// File: rtl/mcnco_top.sv
module mcnco_top
    import mcnco_pkg::*;
#(
    parameter int CH           = 4,
    parameter int LANES        = 2,
    parameter int BANKS        = 8,
    parameter int PHASE_W      = 24,
    parameter int ADDR_W       = 10,
    parameter int WAVE_W       = 16,
    parameter int EXTRACT_BANK = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [$clog2(BANKS)-1:0] cfg_bank,
    input  logic [$clog2(CH)-1:0]    cfg_chan,
    input  logic [PHASE_W-1:0]       cfg_inc,
    input  logic [$clog2(BANKS)-1:0] bank_sel,
    input  logic                     in_valid,
    output logic                     out_valid,
    output logic                     out_slot,
    output logic [$clog2(BANKS)-1:0] out_bank,
    output logic                     out_hit,
    output logic signed [WAVE_W-1:0] lane0_wave,
    output logic signed [WAVE_W-1:0] lane1_wave
);

    localparam int BANK_W = $clog2(BANKS);
    localparam int SLOT_W = 1;

    slot_e                slot;
    logic [BANK_W-1:0]    bank_eff;
    logic [PHASE_W-1:0]   lane_inc [LANES];
    logic [ADDR_W-1:0]    lane_addr [LANES];
    logic signed [WAVE_W-1:0] wave2 [LANES];

    logic              v1, v2, hit1, hit2;
    slot_e             slot1, slot2;
    logic [BANK_W-1:0] bank1, bank2;

    mcnco_slot_fsm #(.BANK_W(BANK_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .bank_sel (bank_sel),
        .slot     (slot),
        .bank_eff (bank_eff)
    );

    mcnco_inc_table #(
        .BANKS(BANKS), .CH(CH), .LANES(LANES), .PW(PHASE_W), .SLOT_W(SLOT_W)
    ) u_tbl (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_chan (cfg_chan),
        .wr_data (cfg_inc),
        .rd_bank (bank_eff),
        .rd_slot (slot),
        .rd_inc  (lane_inc)
    );

    mcnco_phase_bank #(
        .CH(CH), .LANES(LANES), .PW(PHASE_W), .AW(ADDR_W), .SLOT_W(SLOT_W)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .slot   (slot),
        .inc    (lane_inc),
        .addr_q (lane_addr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_rom
        mcnco_sine_rom #(.AW(ADDR_W), .DW(WAVE_W)) u_rom (
            .clk    (clk),
            .en     (v1),
            .addr   (lane_addr[l]),
            .data_q (wave2[l])
        );
    end

    // Stage 1: control alongside the phase address register
    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            hit1  <= 1'b0;
            slot1 <= SLOT_EVEN;
            bank1 <= '0;
        end else begin
            v1   <= in_valid;
            hit1 <= in_valid && (bank_eff == BANK_W'(EXTRACT_BANK));
            if (in_valid) begin
                slot1 <= slot;
                bank1 <= bank_eff;
            end
        end
    end

    // Stage 2: control alongside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            v2    <= 1'b0;
            hit2  <= 1'b0;
            slot2 <= SLOT_EVEN;
            bank2 <= '0;
        end else begin
            v2   <= v1;
            hit2 <= hit1;
            if (v1) begin
                slot2 <= slot1;
                bank2 <= bank1;
            end
        end
    end

    // Stage 3: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_hit    <= 1'b0;
            out_slot   <= 1'b0;
            out_bank   <= '0;
            lane0_wave <= '0;
            lane1_wave <= '0;
        end else begin
            out_valid <= v2;
            out_hit   <= hit2;
            if (v2) begin
                out_slot   <= slot2;
                out_bank   <= bank2;
                lane0_wave <= wave2[0];
                lane1_wave <= wave2[1];
            end
        end
    end

endmodule

// File: rtl/mcnco_chk.sv
module mcnco_chk #(
    parameter int BW       = 3,
    parameter int HIT_BANK = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic          out_slot,
    input logic [BW-1:0] out_bank,
    input logic          out_hit
);

    logic [1:0]    seen_q = '0;
    logic          prev_slot_q;
    logic [BW-1:0] frame_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q       <= '0;
            prev_slot_q  <= 1'b1;
            frame_bank_q <= '0;
        end else begin
            if (seen_q != 2'd3)
                seen_q <= seen_q + 2'd1;
            if (out_valid) begin
                prev_slot_q <= out_slot;
                if (!out_slot)
                    frame_bank_q <= out_bank;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_hit && !out_slot));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6
    slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_slot != prev_slot_q));

    // R8
    frame_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_slot) |-> (out_bank == frame_bank_q));

    // R10
    hit_qual_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_valid && (out_bank == BW'(HIT_BANK))));

    // R10
    hit_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_bank == BW'(HIT_BANK))) |-> out_hit);

endmodule

bind mcnco_top mcnco_chk #(.BW(BANK_W), .HIT_BANK(EXTRACT_BANK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .out_bank  (out_bank),
    .out_hit   (out_hit)
);

// File: tb/sim_mcnco_top.sv
`timescale 1ns/1ps
module sim_mcnco_top;

    localparam int XB = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [1:0]  cfg_chan = '0;
    logic [23:0] cfg_inc = '0;
    logic [2:0]  bank_sel = '0;
    logic        in_valid = 1'b0;
    logic        out_valid, out_slot, out_hit;
    logic [2:0]  out_bank;
    logic signed [15:0] lane0_wave, lane1_wave;

    mcnco_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_chan(cfg_chan), .cfg_inc(cfg_inc), .bank_sel(bank_sel),
        .in_valid(in_valid), .out_valid(out_valid), .out_slot(out_slot),
        .out_bank(out_bank), .out_hit(out_hit),
        .lane0_wave(lane0_wave), .lane1_wave(lane1_wave)
    );

    typedef struct {
        bit v; int slot; int bank; bit hit; int w0; int w1;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails = 0;
    bit          started = 0;
    bit          done = 0;
    int          cyc = 0;
    int unsigned acc[4];
    int unsigned tbl[8][4];
    int          m_slot = 0;
    int          m_frame = 0;

    function automatic int ref_sine(input int k);
        real x;
        x = 32767.0 * $sin(2.0 * $acos(-1.0) * real'(k) / 1024.0);
        return (x < 0.0) ? $rtoi(x - 0.5) : $rtoi(x + 0.5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference model: compare, then advance on the inputs of the coming edge
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (started) begin
            e = q.pop_front();
            chk(out_valid == e.v, "R2", "out_valid", int'(out_valid), int'(e.v));
            chk(out_hit == e.hit, "R10", "out_hit", int'(out_hit), int'(e.hit));
            if (e.v) begin
                chk(int'(out_slot) == e.slot, "R6", "out_slot", int'(out_slot), e.slot);
                chk(int'(out_bank) == e.bank, "R8", "out_bank", int'(out_bank), e.bank);
                chk(int'(lane0_wave) == e.w0, "R3 R4 R5 R7 R9", "lane0", int'(lane0_wave), e.w0);
                chk(int'(lane1_wave) == e.w1, "R3 R4 R5 R7 R9", "lane1", int'(lane1_wave), e.w1);
            end
        end
        if (rst) begin
            for (int c = 0; c < 4; c++) acc[c] = 0;
            m_slot  = 0;
            m_frame = 0;
            q.delete();
            e = '{v: 0, slot: 0, bank: 0, hit: 0, w0: 0, w1: 0};
            for (int i = 0; i < 3; i++) q.push_back(e);
            started = 1;
        end else if (started) begin
            e = '{v: 0, slot: 0, bank: 0, hit: 0, w0: 0, w1: 0};
            if (in_valid) begin
                int b;
                int w[2];
                b = (m_slot == 0) ? int'(bank_sel) : m_frame;
                for (int l = 0; l < 2; l++) begin
                    int ch;
                    ch = 2 * m_slot + l;
                    w[l] = ref_sine(int'(acc[ch] >> 14));
                    acc[ch] = (acc[ch] + tbl[b][ch]) & 32'h00FF_FFFF;
                end
                e = '{v: 1, slot: m_slot, bank: b, hit: (b == XB), w0: w[0], w1: w[1]};
                if (m_slot == 0) m_frame = b;
                m_slot ^= 1;
            end
            q.push_back(e);
        end
        if (cfg_we) tbl[cfg_bank][cfg_chan] = cfg_inc;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic drive(input bit v, input int b);
        @(posedge clk); #1;
        cfg_we = 0; in_valid = v; bank_sel = 3'(b);
    endtask

    task automatic wr(input bit v, input int vb, input int b, input int c, input int val);
        @(posedge clk); #1;
        in_valid = v; bank_sel = 3'(vb);
        cfg_we = 1; cfg_bank = 3'(b); cfg_chan = 2'(c); cfg_inc = 24'(val);
    endtask

    task automatic reset_check();
        @(negedge clk); #1;
        chk(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
        chk(out_slot == 0, "R1", "out_slot", int'(out_slot), 0);
        chk(out_hit == 0, "R1", "out_hit", int'(out_hit), 0);
        chk(lane0_wave == 0, "R1", "lane0", int'(lane0_wave), 0);
        chk(lane1_wave == 0, "R1", "lane1", int'(lane1_wave), 0);
    endtask

    initial begin
        repeat (3) drive(0, 0);
        @(posedge clk); #1; rst = 0;
        reset_check();
        // R7: fill every table entry
        for (int b = 0; b < 8; b++)
            for (int c = 0; c < 4; c++)
                wr(0, 0, b, c, (b == 7) ? (24'hF80000 + c * 24'h1000)
                                        : ((b + 1) * 24'h011111 + c * 24'h000357));
        // Continuous valid, bank 0
        for (int i = 0; i < 40; i++) drive(1, 0);
        // R2 R6: gapped valid
        for (int i = 0; i < 30; i++) drive((i % 3) != 1, 1);
        // R8 R9: bank requests changing on odd and even slots
        for (int i = 0; i < 48; i++) drive(1, (i / 3) % 8);
        // R7: write in the same cycle as a valid sample on that bank
        wr(1, 2, 2, 0, 24'h123456);
        wr(1, 2, 2, 1, 24'h0ABCDE);
        for (int i = 0; i < 12; i++) drive(1, 2);
        // R3: near full-scale steps wrap the accumulators
        for (int i = 0; i < 60; i++) drive(1, 7);
        // R10: extracted bank interleaved with others
        for (int i = 0; i < 24; i++) drive(1, (i < 12) ? XB : 4);
        // R1: reset mid-stream
        for (int i = 0; i < 5; i++) drive(1, 3);
        @(posedge clk); #1; rst = 1; in_valid = 0;
        drive(0, 0);
        @(posedge clk); #1; rst = 0;
        reset_check();
        for (int i = 0; i < 30; i++) drive(1, XB);
        for (int i = 0; i < 6; i++) drive(0, 0);
        @(negedge clk); #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule